// File: doc/BRIEF.md
# Inactivity Power-Timeout Controller

This block drives the power-control pin of a single card function. It switches the function off when nothing has happened for a programmable time. A free-running prescaler divides the input clock by 2^PRESC_W, which is 2^17 by default. An 8-bit timeout counter counts those prescaled ticks up to a terminal count held in a register. The timeout is therefore (2^PRESC_W / f_clk) × N, with N in the range 0 to 255.

Two kinds of activity keep the function awake: a host I/O access, and a ring-indicate service request. When a mode input selects hardware power management, activity turns the power bit on and restarts the interval. The bit is turned off when the counter reaches the terminal count. When the mode input selects software control, the power bit is an ordinary output that only software writes can change.

The pin polarity is programmable. Both register values are loaded and read back through a small parallel port.

Top module: `pwr_timeout_ctrl`

## Requirements
- R1: After reset, the power bit and the polarity bit are 0, the terminal count is 0, and the pin is low.
- R2: The control register holds the power bit at bit 0 and the polarity bit at bit 1. Bits 7:2 read as 0 and writes to them are ignored. The pin equals the power bit when polarity is 0 and its inverse when polarity is 1.
- R3: A write with wr_sel_i=0 loads the control register and a write with wr_sel_i=1 loads the terminal count. Reads use rd_sel_i with the same encoding, and both registers read back in either mode.
- R4: In software mode (hw_pm_i=0), the power bit changes only on control-register writes. Activity and timeouts have no effect on it.
- R5: In hardware mode, with a nonzero terminal count, io_access_i or ring_req_i sets the power bit on the next clock edge.
- R6: In hardware mode, the power bit clears exactly N·2^PRESC_W clock edges after the edge that captured the last activity, where N is the terminal count.
- R7: In hardware mode with a terminal count of 0, the power bit is held at 0. Neither activity nor software writes can set it.
- R8: Writing the terminal count restarts the prescaler and the counter, so the full interval is measured from that write.
- R9: An expired counter holds its value and does not wrap, so no further timeout occurs until new activity.
- R10: In hardware mode, software writes to the power bit are honoured, provided the terminal count is nonzero and there is no activity in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, also the prescaler source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 terminal count |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read source: 0 control, 1 terminal count |
| rd_data_o | output | 8 | Read data |
| io_access_i | input | 1 | Host I/O access strobe |
| ring_req_i | input | 1 | Ring-indicate service request strobe |
| hw_pm_i | input | 1 | 1 selects hardware power management, 0 selects software control |
| pwr_pin_o | output | 1 | Polarity-adjusted power-control pin |

## Verification
The hardest condition to reach is a counter that sits expired while the power bit is set. Only that state can reveal a counter that wraps instead of holding. The stimulus lets a timeout expire and then writes the power bit back to 1 in hardware mode. It then waits well beyond 256 prescaled periods to confirm that no second clear ever arrives. The bench shrinks the prescaler so that exact-cycle expiry edges can be checked within a short run.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned CTRL_PON_BIT = 0;
  localparam int unsigned CTRL_POL_BIT = 1;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_TC   = 1'b1;
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int unsigned PRESC_W = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  assign tick_o = &pre_q;

  p_presc_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pre_q == '0));
endmodule

// File: rtl/pt_timeout_cnt.sv
module pt_timeout_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] tc_i,
  output logic             reach_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign expired_o = (cnt_q == tc_i);
  // counter steps onto terminal count this edge
  assign reach_o   = tick_i && !expired_o && (cnt_inc == {1'b0, tc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_inc[CNT_W-1:0];
  end

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tc_i);
  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pt_ctrl_reg.sv
module pt_ctrl_reg
  import pt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_tc_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hw_pm_i,
  input  logic              act_i,
  input  logic              reach_i,
  output logic              pon_o,
  output logic              pol_o,
  output logic [DATA_W-1:0] tc_o
);
  logic pon_q, pol_q, pon_d, tc_zero;
  logic [DATA_W-1:0] tc_q;

  assign tc_zero = (tc_q == '0);

  always_comb begin
    pon_d = pon_q;
    if (wr_ctrl_i) pon_d = wr_data_i[CTRL_PON_BIT];
    if (hw_pm_i) begin
      if (tc_zero)      pon_d = 1'b0;
      else if (act_i)   pon_d = 1'b1;
      else if (reach_i) pon_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pon_q <= 1'b0;
      pol_q <= 1'b0;
      tc_q  <= '0;
    end else begin
      pon_q <= pon_d;
      if (wr_ctrl_i) pol_q <= wr_data_i[CTRL_POL_BIT];
      if (wr_tc_i)   tc_q  <= wr_data_i;
    end
  end

  assign pon_o = pon_q;
  assign pol_o = pol_q;
  assign tc_o  = tc_q;

  p_sw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_pm_i && !wr_ctrl_i) |=> $stable(pon_q));
  p_act_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_pm_i && act_i && !tc_zero) |=> pon_q);
  p_expire_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_pm_i && reach_i && !act_i) |=> !pon_q);
  p_zero_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_pm_i && tc_zero) |=> !pon_q);
endmodule

// File: rtl/pwr_timeout_ctrl.sv
module pwr_timeout_ctrl
  import pt_pkg::*;
#(
  parameter int unsigned PRESC_W = 17,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              io_access_i,
  input  logic              ring_req_i,
  input  logic              hw_pm_i,
  output logic              pwr_pin_o
);
  logic wr_ctrl, wr_tc, act, clr, tick, reach, expired, pon, pol;
  logic [DATA_W-1:0] tc;

  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_tc   = wr_en_i && (wr_sel_i == SEL_TC);
  assign act     = io_access_i || ring_req_i;
  assign clr     = act || wr_tc;

  pt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_o(tick));

  pt_timeout_cnt #(.CNT_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_i(tick),
    .tc_i(tc), .reach_o(reach), .expired_o(expired));

  pt_ctrl_reg #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctrl_i(wr_ctrl), .wr_tc_i(wr_tc),
    .wr_data_i(wr_data_i), .hw_pm_i(hw_pm_i), .act_i(act), .reach_i(reach),
    .pon_o(pon), .pol_o(pol), .tc_o(tc));

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == SEL_TC) rd_data_o = tc;
    else begin
      rd_data_o[CTRL_PON_BIT] = pon;
      rd_data_o[CTRL_POL_BIT] = pol;
    end
  end

  assign pwr_pin_o = pon ^ pol;

  p_expired_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_pm_i && $past(hw_pm_i) && expired && $past(expired) && !$past(act)
     && !$past(wr_en_i) && !$past(pon)) |-> !pon);
endmodule

// File: tb/tb_pwr_timeout_ctrl.sv
module tb_pwr_timeout_ctrl;
  localparam int P = 4;
  localparam int PER = 1 << P;

  logic clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0, wr_sel_i = 0, rd_sel_i = 0;
  logic [7:0] wr_data_i = 0;
  logic io_access_i = 0, ring_req_i = 0, hw_pm_i = 0;
  logic [7:0] rd_data_o;
  logic pwr_pin_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pwr_timeout_ctrl #(.PRESC_W(P), .DATA_W(8)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .io_access_i(io_access_i), .ring_req_i(ring_req_i), .hw_pm_i(hw_pm_i),
    .pwr_pin_o(pwr_pin_o));

  // {hw, wdata, exp_rd, exp_pin}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 8'h01, 8'h01, 1'b1},
    {1'b0, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h02, 8'h02, 1'b1},
    {1'b0, 8'h03, 8'h03, 1'b0},
    {1'b0, 8'hFD, 8'h01, 1'b1},
    {1'b0, 8'hFE, 8'h02, 1'b1}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic pulse_io();
    io_access_i = 1; @(negedge clk_i); io_access_i = 0;
  endtask

  task automatic pulse_ring();
    ring_req_i = 1; @(negedge clk_i); ring_req_i = 0;
  endtask

  function automatic logic pon();
    return dut.rd_data_o[0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rd_sel_i = 0;
    #1;
    chk("R1 ctrl", rd_data_o, 8'h00);
    chk("R1 pin", pwr_pin_o, 1'b0);
    rd_sel_i = 1; #1;
    chk("R1 tc", rd_data_o, 8'h00);
    rst_ni = 1; rd_sel_i = 0;
    cyc(1);

    for (int i = 0; i < 6; i++) begin
      hw_pm_i = VEC[i][17];
      wr(1'b0, VEC[i][16:9]);
      pulse_io();
      chk("R2/R3/R4 rd", rd_data_o, VEC[i][8:1]);
      chk("R2 pin", pwr_pin_o, VEC[i][0]);
    end

    // R7: hw mode, tc = 0
    hw_pm_i = 1;
    wr(1'b0, 8'h00);
    pulse_io();
    chk("R7 act", rd_data_o[0], 1'b0);
    wr(1'b0, 8'h01);
    chk("R7 write", rd_data_o[0], 1'b0);
    chk("R7 pin", pwr_pin_o, 1'b0);

    // R3: tc readback
    wr(1'b1, 8'd3);
    rd_sel_i = 1;
    cyc(1);
    chk("R3 tc", rd_data_o, 8'd3);
    rd_sel_i = 0;

    // R5/R6: io activity then exact expiry
    pulse_io();
    chk("R5 io", rd_data_o[0], 1'b1);
    chk("R5 pin", pwr_pin_o, 1'b1);
    cyc(3*PER - 1);
    chk("R6 before", rd_data_o[0], 1'b1);
    cyc(1);
    chk("R6 expire", rd_data_o[0], 1'b0);
    chk("R6 pin", pwr_pin_o, 1'b0);

    // R5: ring request, then restart by io
    pulse_ring();
    chk("R5 ring", rd_data_o[0], 1'b1);
    cyc(30);
    pulse_io();
    cyc(3*PER - 1);
    chk("R5 restart", rd_data_o[0], 1'b1);
    cyc(1);
    chk("R5 restart expire", rd_data_o[0], 1'b0);

    // R8: tc write restarts interval
    pulse_io();
    cyc(30);
    wr(1'b1, 8'd3);
    cyc(3*PER - 1);
    chk("R8 before", rd_data_o[0], 1'b1);
    cyc(1);
    chk("R8 expire", rd_data_o[0], 1'b0);

    // R9/R10: sw set after expiry, no second timeout
    wr(1'b0, 8'h01);
    chk("R10 write", rd_data_o[0], 1'b1);
    cyc(300*PER);
    chk("R9 hold", rd_data_o[0], 1'b1);

    // R2 in hw mode with inverted polarity
    wr(1'b0, 8'h02);
    pulse_io();
    chk("R2 inv on", pwr_pin_o, 1'b0);
    cyc(3*PER);
    chk("R2 inv off", pwr_pin_o, 1'b1);

    // R4: sw mode ignores activity and timeout
    hw_pm_i = 0;
    wr(1'b0, 8'h00);
    pulse_io();
    pulse_ring();
    chk("R4 act", rd_data_o[0], 1'b0);
    wr(1'b1, 8'd1);
    wr(1'b0, 8'h01);
    cyc(10*PER);
    chk("R4 timeout", rd_data_o[0], 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule